// File: doc/BRIEF.md
# MDIO Management Frame Master

This block turns one host command into one clause 22 management frame on the MDC/MDIO pair. The host sees two 32-bit registers behind a plain write/read port. The control register carries the start code, the op code, the PHY and register addresses, an MDC divider setting and a launch bit. The data register carries the outgoing write word in its low half and, after a read frame, the word returned by the PHY in its high half.

Setting the launch bit starts one frame. The block latches everything it needs on the cycle the frame begins. It then shifts the 64 frame bits out, most significant first, with each bit changing on a falling MDC edge. It samples MDIO on rising MDC edges while the PHY owns the line. When the last bit ends, hardware clears the launch bit. Software polls that bit to learn that the frame is done and, for a read, that the returned word is ready.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset both registers read as zero, MDC is low and the MDIO output enable is low.
- R2: A frame is exactly 64 MDC periods: 32 ones, then start code (control bits 13:12), op code (bits 11:10), PHY address (bits 9:5), register address (bits 4:0), two turnaround bits and 16 data bits, each field most significant bit first.
- R3: When the op code is not 2'b10, the output enable stays high for all 64 bits, the turnaround is sent as 1 then 0, and the data field is bits 15:0 of the data register.
- R4: When the op code is 2'b10 (read), the output enable is high through the first turnaround bit and low from the second turnaround bit to the end of the frame. The 16 bits sampled in the data field are stored, first sample as bit 31, in bits 31:16 of the data register.
- R5: Writing the control register with bit 20 set starts one frame. Bit 20 reads 1 until the frame ends and 0 afterwards, and no further frame follows.
- R6: While bit 20 reads 1, writes to the control register are ignored, so a second launch or new field values neither disturb the running frame nor start another.
- R7: Each MDC half period lasts N+1 system clocks, where N is control bits 31:24 latched at frame start. MDIO changes only on falling MDC edges and is sampled on rising ones.
- R8: Host writes to the data register change only bits 15:0. Bits 31:16 change only at the end of a read frame.
- R9: Between frames, MDC rests low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_wr_sel | input | 1 | Write target: 0 control, 1 data |
| host_wdata | input | 32 | Write value |
| host_rd_sel | input | 1 | Read source: 0 control, 1 data |
| host_rdata | output | 32 | Read value of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The hardest case to reach from the ports is a host write that arrives in the middle of a running frame. The launch bit is still set and the divider is partway through a bit, so a faulty design could relaunch or pick up the new fields. The bench launches a read frame and, about thirty clocks later, writes a control word with different fields and the launch bit set. A scoreboard compares every bit against the original frame. The bench then confirms that no extra MDC edge follows and that the register still holds the first command. A small PHY model drives returned data after each rising edge, so the capture path is exercised with patterns that have both end bits set.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;
   localparam int REG_W  = 32;
   localparam int DIV_W  = 8;

   // control register field positions
   localparam int F_REG_LO = 0;
   localparam int F_PHY_LO = 5;
   localparam int F_OP_LO  = 10;
   localparam int F_ST_LO  = 12;
   localparam int F_GO     = 20;
   localparam int F_DIV_LO = 24;

   localparam logic [1:0] OP_READ = 2'b10;
   localparam logic [1:0] TA_DRIVE = 2'b10;
   localparam logic [1:0] TA_FLOAT = 2'b11;

   typedef struct packed {
      logic [1:0]        st;
      logic [1:0]        op;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regad;
      logic [DIV_W-1:0]  half;
   } mdio_cmd_t;

   typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} seq_state_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_W    = 8,
   parameter int IDLE_LVL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);
   logic [DIV_W-1:0] cnt;
   logic             ph;
   logic             wrap;

   assign wrap      = run && (cnt == half);
   assign rise_tick = wrap && !ph;
   assign fall_tick = wrap && ph;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         ph  <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         ph  <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         ph  <= ~ph;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end

   generate
      if (IDLE_LVL == 0) begin : g_idle_low
         assign mdc = ph;
      end else begin : g_idle_high
         assign mdc = ph | ~run;
      end
   endgenerate

   // R9: resting level of MDC outside a frame
   p_mdc_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (mdc == 1'(IDLE_LVL)));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  mdio_cmd_t         cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise_tick,
   input  logic              fall_tick,
   input  logic              mdio_i,
   output logic              running,
   output logic [DIV_W-1:0]  half_q,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              done,
   output logic              rd_done,
   output logic [DATA_W-1:0] rdata
);
   localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
   localparam int BW        = $clog2(FRAME_LEN);
   localparam int RD_OFF_I  = PRE_LEN + 2 + 2 + 2*ADDR_W + 1;
   localparam int DSTART_I  = RD_OFF_I + 1;
   localparam logic [BW-1:0] LAST_IDX = BW'(FRAME_LEN - 1);
   localparam logic [BW-1:0] RD_OFF   = BW'(RD_OFF_I);
   localparam logic [BW-1:0] DSTART   = BW'(DSTART_I);

   seq_state_t            st;
   logic [FRAME_LEN-1:0]  shreg;
   logic [BW-1:0]         bidx;
   logic [1:0]            op_q;
   logic                  is_rd;
   logic                  start;
   logic [1:0]            ta;

   assign running = (st == S_RUN);
   assign is_rd   = (op_q == OP_READ);
   assign start   = (st == S_IDLE) && go;
   assign ta      = (cmd.op == OP_READ) ? TA_FLOAT : TA_DRIVE;
   assign done    = running && fall_tick && (bidx == LAST_IDX);
   assign rd_done = done && is_rd;
   assign mdio_o  = running ? shreg[FRAME_LEN-1] : 1'b0;
   assign mdio_oe = running && (!is_rd || (bidx < RD_OFF));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         shreg  <= '0;
         bidx   <= '0;
         op_q   <= '0;
         half_q <= '0;
         rdata  <= '0;
      end else if (start) begin
         st     <= S_RUN;
         shreg  <= {{PRE_LEN{1'b1}}, cmd.st, cmd.op, cmd.phy, cmd.regad, ta, wdata};
         bidx   <= '0;
         op_q   <= cmd.op;
         half_q <= cmd.half;
         rdata  <= '0;
      end else if (running) begin
         if (rise_tick && is_rd && (bidx >= DSTART))
            rdata <= {rdata[DATA_W-2:0], mdio_i};
         if (fall_tick) begin
            if (bidx == LAST_IDX) begin
               st <= S_IDLE;
            end else begin
               shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
               bidx  <= bidx + BW'(1);
            end
         end
      end
   end

   // R7: output bit moves only on a falling MDC edge
   p_shift_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      running && !fall_tick |=> $stable(mdio_o));
   // R6: latched op and divider hold for the whole frame
   p_fields_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
      running && !done |=> ($stable(op_q) && $stable(half_q)));
   // R4: line is released whenever a read frame reaches its data field
   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tick && running && is_rd && (bidx >= DSTART) |-> !mdio_oe);
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
   import mdio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_wr_sel,
   input  logic [REG_W-1:0]  host_wdata,
   input  logic              host_rd_sel,
   output logic [REG_W-1:0]  host_rdata,
   input  logic              done,
   input  logic              rd_done,
   input  logic [DATA_W-1:0] rdata,
   output logic              go,
   output mdio_cmd_t         cmd,
   output logic [DATA_W-1:0] wdata
);
   logic [DATA_W-1:0] data_hi;
   logic [REG_W-1:0]  ctl_view;
   logic              unused_wbits;

   assign unused_wbits = ^{host_wdata[23:21], host_wdata[19:14], host_wdata[31:16]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go   <= 1'b0;
         cmd  <= '0;
      end else if (done) begin
         go   <= 1'b0;
      end else if (host_wr && !host_wr_sel && !go) begin
         go        <= host_wdata[F_GO];
         cmd.st    <= host_wdata[F_ST_LO  +: 2];
         cmd.op    <= host_wdata[F_OP_LO  +: 2];
         cmd.phy   <= host_wdata[F_PHY_LO +: ADDR_W];
         cmd.regad <= host_wdata[F_REG_LO +: ADDR_W];
         cmd.half  <= host_wdata[F_DIV_LO +: DIV_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wdata   <= '0;
         data_hi <= '0;
      end else begin
         if (host_wr && host_wr_sel)
            wdata <= host_wdata[DATA_W-1:0];
         if (rd_done)
            data_hi <= rdata;
      end
   end

   always_comb begin
      ctl_view = '0;
      ctl_view[F_GO]               = go;
      ctl_view[F_ST_LO  +: 2]      = cmd.st;
      ctl_view[F_OP_LO  +: 2]      = cmd.op;
      ctl_view[F_PHY_LO +: ADDR_W] = cmd.phy;
      ctl_view[F_REG_LO +: ADDR_W] = cmd.regad;
      ctl_view[F_DIV_LO +: DIV_W]  = cmd.half;
   end

   assign host_rdata = host_rd_sel ? {data_hi, wdata} : ctl_view;

   // R5: the launch bit drops right after the frame ends
   p_go_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !go);
   // R8: upper data half moves only on a completed read frame
   p_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_done |=> $stable(data_hi));
   // R6: control fields are frozen while a frame is pending or running
   p_cmd_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      go && !done |=> $stable(cmd));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
   import mdio_pkg::*;
#(
   parameter int PRE_LEN  = 32,
   parameter int IDLE_LVL = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic        host_wr_sel,
   input  logic [31:0] host_wdata,
   input  logic        host_rd_sel,
   output logic [31:0] host_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..64");
      end
      if (IDLE_LVL != 0 && IDLE_LVL != 1) begin : g_bad_idle
         $error("IDLE_LVL must be 0 or 1");
      end
      if (2*DATA_W != REG_W) begin : g_bad_data
         $error("data register must hold two data words");
      end
   endgenerate

   logic              go;
   mdio_cmd_t         cmd;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] rdata;
   logic              running, done, rd_done;
   logic              rise_tick, fall_tick;
   logic [DIV_W-1:0]  half_q;

   mdio_host_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (host_wr),
      .host_wr_sel (host_wr_sel),
      .host_wdata  (host_wdata),
      .host_rd_sel (host_rd_sel),
      .host_rdata  (host_rdata),
      .done        (done),
      .rd_done     (rd_done),
      .rdata       (rdata),
      .go          (go),
      .cmd         (cmd),
      .wdata       (wdata)
   );

   mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .cmd       (cmd),
      .wdata     (wdata),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .running   (running),
      .half_q    (half_q),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .done      (done),
      .rd_done   (rd_done),
      .rdata     (rdata)
   );

   mdio_clk_div #(.DIV_W(DIV_W), .IDLE_LVL(IDLE_LVL)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (running),
      .half      (half_q),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );
endmodule

// File: tb/mdio_frame_master_test.sv
`timescale 1ns/1ps
module mdio_frame_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_wr_sel = 1'b0;
   logic [31:0] host_wdata = '0;
   logic        host_rd_sel = 1'b0;
   logic [31:0] host_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #2.5 clk = ~clk;

   mdio_frame_master uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wr_sel(host_wr_sel),
      .host_wdata(host_wdata), .host_rd_sel(host_rd_sel), .host_rdata(host_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   // scoreboard entries: {check value, expected oe, expected value}
   logic [2:0]  exp_q[$];
   int          rise_idx = 0;
   int          cur_half = 0;
   bit          rd_frame = 0;
   logic [15:0] phy_word = '0;
   logic [15:0] exp_hi = '0;
   int          cyc = 0;
   int          last_rise = 0;
   logic        mdc_q = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // monitor: pops one expected bit per rising MDC edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n && mdc && !mdc_q) begin
         if (exp_q.size() == 0) begin
            check(0, "R5 extra MDC rise", 32'(rise_idx), 32'(0));
         end else begin
            logic [2:0] e;
            e = exp_q.pop_front();
            check(mdio_oe == e[1], $sformatf("R3/R4 oe at bit %0d", rise_idx), 32'(mdio_oe), 32'(e[1]));
            if (e[2])
               check(mdio_o == e[0], $sformatf("R2 value at bit %0d", rise_idx), 32'(mdio_o), 32'(e[0]));
            if (rise_idx > 0)
               check(cyc - last_rise == 2*(cur_half+1), "R7 MDC period",
                     32'(cyc - last_rise), 32'(2*(cur_half+1)));
            if (rd_frame && rise_idx >= 47 && rise_idx <= 62)
               mdio_i = phy_word[15-(rise_idx-47)];
            rise_idx++;
         end
         last_rise = cyc;
      end
      mdc_q = mdc;
   end

   task automatic host_write(input bit sel, input logic [31:0] v);
      @(negedge clk);
      host_wr = 1'b1; host_wr_sel = sel; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input bit sel, output logic [31:0] v);
      @(negedge clk);
      host_rd_sel = sel;
      #1 v = host_rdata;
   endtask

   task automatic run_frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] ra, input logic [7:0] half, input logic [15:0] wd,
                            input logic [15:0] pw, input bit poke);
      logic [63:0] fr;
      logic [1:0]  ta;
      logic [31:0] cmdw, r;
      bit          isr;
      isr = (op == 2'b10);
      ta  = isr ? 2'b11 : 2'b10;
      fr  = {32'hFFFF_FFFF, st, op, phy, ra, ta, wd};
      for (int i = 0; i < 64; i++) begin
         bit oe;
         oe = !isr || (i < 47);
         exp_q.push_back({oe, oe, fr[63-i]});
      end
      cur_half = half; phy_word = pw; rise_idx = 0; rd_frame = isr;
      host_write(1'b1, {16'hFFFF, wd});
      cmdw = {half, 3'b000, 1'b1, 6'b0, st, op, phy, ra};
      host_write(1'b0, cmdw);
      host_read(1'b0, r);
      check(r[20] == 1'b1, "R5 go set during frame", r, cmdw);
      if (poke) begin
         repeat (30) @(negedge clk);
         host_write(1'b0, 32'h0012_3FFF | 32'h0010_0000);
         host_read(1'b0, r);
         check(r == cmdw, "R6 control write ignored while busy", r, cmdw);
      end
      do host_read(1'b0, r); while (r[20] && !finished);
      check(exp_q.size() == 0, "R2 all 64 bits sent", 32'(exp_q.size()), 32'(0));
      check(r == (cmdw & ~32'h0010_0000), "R5 go cleared, fields kept", r, cmdw & ~32'h0010_0000);
      if (isr) exp_hi = pw;
      host_read(1'b1, r);
      check(r == {exp_hi, wd}, "R4 R8 data register", r, {exp_hi, wd});
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle pins", {mdc, mdio_oe}, 32'(0));
      repeat (40) @(negedge clk);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 still idle, no relaunch", {mdc, mdio_oe}, 32'(0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      host_read(1'b0, r);
      check(r == 32'h0, "R1 control reset", r, 32'h0);
      host_read(1'b1, r);
      check(r == 32'h0, "R1 data reset", r, 32'h0);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins at reset", {mdc, mdio_oe}, 32'(0));

      // R3 write frame, R7 half period 2 clocks
      run_frame(2'b01, 2'b01, 5'h13, 5'h0A, 8'd1, 16'hA5C3, 16'h0000, 1'b0);
      // R4 read frame, R7 half period 3 clocks
      run_frame(2'b01, 2'b10, 5'h01, 5'h02, 8'd2, 16'h7777, 16'h3C96, 1'b0);
      // R6 read frame with mid-frame control write, fastest divider
      run_frame(2'b01, 2'b10, 5'h1F, 5'h00, 8'd0, 16'h0F0F, 16'h8001, 1'b1);
      // R2 R3 arbitrary codes, R8 high half kept across a non-read frame
      run_frame(2'b00, 2'b11, 5'h00, 5'h1F, 8'd3, 16'h8001, 16'hFFFF, 1'b0);

      // R8 host write to data register touches only the low half
      host_write(1'b1, 32'h5555_1234);
      host_read(1'b1, r);
      check(r == {exp_hi, 16'h1234}, "R8 high half unaffected by host", r, {exp_hi, 16'h1234});

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule